// File: doc/BRIEF.md
# Indexed Super-I/O Configuration Port

This block puts a 256-entry byte-wide configuration space behind two adjacent I/O addresses. A write to the lower address latches an 8-bit index. A write to the upper address stores a byte at that index. A read from the upper address returns the byte at that index. A read from the lower address returns the index itself.

Writes pass through a filter for each index. Indices below 0xE0 and a scattered set in the upper range are read-only. Two indices accept only one exact byte, so any other value is dropped. All other upper-range indices take any byte.

The whole window answers only while bit 1 of a control byte from the host bridge is set. Reset loads fixed defaults. The bus is a single-cycle synchronous strobe interface. The reply data and the claim flag are registered, so they appear one cycle after the strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: While enabled, a write to address 0x3F0 loads the index from the write data. A read of 0x3F0 returns the current index.
- R2: While enabled, a read of 0x3F1 returns the entry at the current index, including read-only entries. Entries below 0xE0 always read 0x00.
- R3: Data writes are dropped when the index is below 0xE0, equals 0xE4, 0xE5, 0xF3, 0xF5 or 0xF7, or lies in 0xE9..0xED, 0xF9..0xFB or 0xFD..0xFF.
- R4: A data write to index 0xE7 is stored only if the byte is 0xFE. A data write to index 0xE8 is stored only if the byte is 0xBE. Any other byte leaves the entry unchanged.
- R5: Every other index from 0xE0 to 0xFF stores any data byte written to it.
- R6: Synchronous active-high reset sets 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. All other entries reset to 0x00.
- R7: While bit 1 of `bridge_ctrl` is clear, no access is acknowledged and reads return 0xFF. Writes change neither the index nor any entry.
- R8: `io_ack` is high in the cycle after a claimed read or write strobe, and low otherwise. `io_rdata` is 0xFF whenever the previous cycle held no claimed read.
- R9: The index resets to 0x00.
- R10: Accesses to addresses other than 0x3F0 and 0x3F1 are not acknowledged and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bridge_ctrl | input | 8 | Bridge control byte; bit 1 enables the window |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, registered |
| io_ack | output | 1 | Access claimed, registered |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that `bridge_ctrl` and the address are steady while a strobe is high. The bench drives each strobe alone for exactly one cycle, changes inputs on the falling edge only, and toggles the enable byte only between accesses. The filter cases are reached by first setting the index and then writing both allowed and refused bytes, followed by a read-back through the data port.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef logic [7:0] byte_t;

  // Power-on value of a configuration entry
  function automatic byte_t fn_reset_val(input byte_t idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int          ADDR_W   = 16,
  parameter int          CTRL_W   = 8,
  parameter int          CTRL_BIT = 1,
  parameter [ADDR_W-1:0] BASE     = 16'h03F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              rd,
  input  logic              wr,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE + 1'b1;

  logic en, hit_idx, hit_dat;

  always_comb begin
    en      = ctrl[CTRL_BIT];
    hit_idx = en && (addr == BASE);
    hit_dat = en && (addr == DAT_ADDR);
    idx_wr  = hit_idx && wr;
    idx_rd  = hit_idx && rd;
    dat_wr  = hit_dat && wr;
    dat_rd  = hit_dat && rd;
  end
endmodule

// File: rtl/sio_wr_filter.sv
module sio_wr_filter
  import sio_cfg_pkg::*;
(
  input  byte_t idx,
  input  byte_t data,
  input  logic  req,
  output logic  we
);
  logic ok;

  always_comb begin
    ok = 1'b1;
    if (idx < 8'hE0) begin
      ok = 1'b0;
    end else begin
      case (idx) inside
        [8'hE4:8'hE5], [8'hE9:8'hED], [8'hF9:8'hFB], [8'hFD:8'hFF],
        8'hF3, 8'hF5, 8'hF7: ok = 1'b0;
        8'hE7:               ok = (data == 8'hFE);
        8'hE8:               ok = (data == 8'hBE);
        default:             ok = 1'b1;
      endcase
    end
    we = req && ok;
  end
endmodule

// File: rtl/sio_cfg_store.sv
module sio_cfg_store
  import sio_cfg_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int WIN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);
  localparam int NWIN = 2 ** WIN_W;
  localparam int LO   = 2 ** IDX_W - NWIN;

  logic [7:0] regs [NWIN];

  logic w_in, r_in;
  assign w_in = &widx[IDX_W-1:WIN_W];
  assign r_in = &ridx[IDX_W-1:WIN_W];

  for (genvar g = 0; g < NWIN; g++) begin : g_ent
    localparam logic [7:0] RV = fn_reset_val(byte_t'(LO + g));
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= RV;
      else if (we && w_in && widx[WIN_W-1:0] == WIN_W'(g))
        regs[g] <= wdata;
    end
  end

  assign rdata = r_in ? regs[ridx[WIN_W-1:0]] : 8'h00;

  // R3
  low_we_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> w_in);

  // R4
  e7_val_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(8'hE7)) |-> wdata == 8'hFE);

  // R4
  e8_val_chk: assert property (@(posedge clk) disable iff (rst)
    (we && widx == IDX_W'(8'hE8)) |-> wdata == 8'hBE);
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          CTRL_W   = 8,
  parameter int          CTRL_BIT = 1,
  parameter [ADDR_W-1:0] BASE     = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] bridge_ctrl,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_ack
);
  localparam int IDX_W = 8;
  localparam int WIN_W = 5;

  logic idx_wr, idx_rd, dat_wr, dat_rd, we;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] ent;

  sio_addr_dec #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CTRL_BIT(CTRL_BIT), .BASE(BASE)) i_dec (
    .addr(io_addr), .ctrl(bridge_ctrl), .rd(io_rd), .wr(io_wr),
    .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd));

  sio_wr_filter i_flt (.idx(idx_q), .data(io_wdata), .req(dat_wr), .we(we));

  sio_cfg_store #(.IDX_W(IDX_W), .WIN_W(WIN_W)) i_store (
    .clk(clk), .rst(rst), .we(we), .widx(idx_q), .wdata(io_wdata),
    .ridx(idx_q), .rdata(ent));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      io_ack   <= 1'b0;
      io_rdata <= 8'hFF;
    end else begin
      if (idx_wr) idx_q <= io_wdata;
      io_ack   <= idx_wr || idx_rd || dat_wr || dat_rd;
      io_rdata <= dat_rd ? ent : (idx_rd ? idx_q : 8'hFF);
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> idx_q == $past(io_wdata));

  // R7
  off_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !bridge_ctrl[CTRL_BIT]) |=> $stable(idx_q));

  // R7
  off_read_chk: assert property (@(posedge clk) disable iff (rst)
    ((io_rd || io_wr) && !bridge_ctrl[CTRL_BIT]) |=> (!io_ack && io_rdata == 8'hFF));

  // R8
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_rd || idx_rd) |=> io_ack);
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bridge_ctrl = 8'h02;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_ack;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst(rst), .bridge_ctrl(bridge_ctrl), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_ack(io_ack));

  localparam logic [15:0] A_IDX = 16'h03F0;
  localparam logic [15:0] A_DAT = 16'h03F1;

  // row = {op, byte}; op 0: set index, 1: write data, 2: read data and expect byte
  localparam int NV = 36;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'hE0}, {2'd2, 8'h3C},                 // R6
    {2'd1, 8'h55}, {2'd2, 8'h55},                 // R5
    {2'd0, 8'hE4}, {2'd1, 8'h77}, {2'd2, 8'h00},  // R3
    {2'd0, 8'h10}, {2'd1, 8'hAA}, {2'd2, 8'h00},  // R3 R2
    {2'd0, 8'hE7}, {2'd1, 8'h12}, {2'd2, 8'hFE},  // R4
    {2'd1, 8'hFE}, {2'd2, 8'hFE},                 // R4
    {2'd0, 8'hE8}, {2'd1, 8'h00}, {2'd2, 8'hBE},  // R4
    {2'd0, 8'hFC}, {2'd1, 8'hA5}, {2'd2, 8'hA5},  // R5
    {2'd0, 8'hFF}, {2'd1, 8'h33}, {2'd2, 8'h00},  // R3
    {2'd0, 8'hEB}, {2'd1, 8'h44}, {2'd2, 8'h00},  // R3
    {2'd0, 8'hEE}, {2'd1, 8'h0F}, {2'd2, 8'h0F},  // R5
    {2'd0, 8'hE6}, {2'd2, 8'hDE},                 // R6
    {2'd0, 8'hE3}, {2'd2, 8'hFC},                 // R6
    {2'd0, 8'hE1}, {2'd2, 8'h00}                  // R6
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got ack/data %h, expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, input string req,
                       input logic exp_ack, input logic [7:0] exp_d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(req, {io_ack, io_rdata}, {exp_ack, exp_d});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 idle after reset", {io_ack, io_rdata}, {1'b0, 8'hFF});
    rst = 1'b0;
    do_rd(A_IDX, "R9 index after reset", 1'b1, 8'h00);
    do_rd(A_DAT, "R2 entry 0x00", 1'b1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][9:8])
        2'd0:    do_wr(A_IDX, VEC[i][7:0]);
        2'd1:    do_wr(A_DAT, VEC[i][7:0]);
        default: do_rd(A_DAT, "R2-R6 table", 1'b1, VEC[i][7:0]);
      endcase
    end

    // R1 index read-back
    do_wr(A_IDX, 8'hEE);
    do_rd(A_IDX, "R1 index read", 1'b1, 8'hEE);

    // R8 ack one cycle after a write strobe, then drops
    @(negedge clk);
    io_addr = A_IDX; io_wdata = 8'hEE; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    check("R8 write ack", {io_ack, io_rdata}, {1'b1, 8'hFF});
    @(negedge clk);
    check("R8 ack drops", {io_ack, io_rdata}, {1'b0, 8'hFF});

    // R7 disabled window
    bridge_ctrl = 8'hFD;
    do_rd(A_DAT, "R7 read while off", 1'b0, 8'hFF);
    do_wr(A_IDX, 8'hE0);
    do_wr(A_DAT, 8'h99);
    bridge_ctrl = 8'h02;
    do_rd(A_IDX, "R7 index kept while off", 1'b1, 8'hEE);
    do_rd(A_DAT, "R7 entry kept while off", 1'b1, 8'h0F);

    // R10 foreign addresses
    do_wr(16'h03F2, 8'h11);
    do_wr(16'h02F1, 8'h22);
    do_rd(16'h03F2, "R10 foreign read", 1'b0, 8'hFF);
    do_rd(A_DAT, "R10 entry untouched", 1'b1, 8'h0F);

    // R5 second pattern on same entry, R4 E8 accepts exact value
    do_wr(A_DAT, 8'hF0);
    do_rd(A_DAT, "R5 rewrite", 1'b1, 8'hF0);
    do_wr(A_IDX, 8'hE8);
    do_wr(A_DAT, 8'hBE);
    do_rd(A_DAT, "R4 E8 exact", 1'b1, 8'hBE);

    // R6 reset restores defaults over written values
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_wr(A_IDX, 8'hE0);
    do_rd(A_DAT, "R6 default after rewrite", 1'b1, 8'h3C);
    do_wr(A_IDX, 8'hEE);
    do_rd(A_DAT, "R6 zero default", 1'b1, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule